// File: doc/BRIEF.md
# Serial EEPROM Command and Page-Program Controller

This block is the command layer behind the serial front end of an SPI EEPROM. The front end sends it chip-select edge pulses and whole received bytes. The block decodes the instruction byte and collects the address. It then streams array bytes or status bytes back to the front end, which shifts them out during the next byte slot. It keeps the write-enable latch. A page write is staged in a page-sized holding buffer. When the frame closes cleanly, the buffer is committed to an external synchronous byte-wide memory, and a timed busy period follows.

Two state machines split the work. The frame machine runs one per chip-select frame:
- F_IDLE (deselected).
- F_OPC (waiting for the instruction).
- F_AH and F_AL (high and low address bytes).
- One terminal state per frame type: F_RD (array read stream), F_WD (page data), F_SD (status data), F_SR (status stream) and F_SKIP (frame discarded).

A falling chip select moves F_IDLE, or any other state, to F_OPC. A rising chip select returns every state to F_IDLE. The instruction byte leaves F_OPC for F_AH, F_SR, F_SD or F_SKIP. F_AH always moves to F_AL, and F_AL moves to F_RD or F_WD.

The program engine runs independently of the frame machine, so status can be polled while a program is in flight. Its states are:
- E_IDLE: waiting for a commit.
- E_CHECK: a one-cycle policy request to an external protection unit. A grant leads to E_PROG for a page or E_TIMER for status; a refusal returns to E_IDLE.
- E_PROG: one buffer slot per cycle, written only where a byte was received.
- E_TIMER: counts the write-cycle length.
- E_DONE: the end pulse, then back to E_IDLE.

Top module: `ee_page_cmd_ctrl`

## Requirements
- R1: After reset the block is idle (`busy`=0, `tx_oe`=0, `wc_done`=0) and the write-enable latch is clear, so a status read returns 0x00.
- R2: An instruction byte is accepted only when bits [7:4] are 0000; bit 3 is ignored; bits [2:0] select 110 set-latch, 100 clear-latch, 101 status read, 001 status write, 011 array read, 010 page write. Status byte layout: bit 0 busy, bit 1 write-enable latch, bits 3:2 block-protect field, bit 7 protect-pin enable, bits 6:4 zero.
- R3: Any other instruction byte discards the rest of the frame: no output is driven (`tx_oe` stays 0) and no state changes until the next chip-select fall.
- R4: An array read (0x03) takes two address bytes, most significant first, and uses only the low `ADDR_W` bits. It returns the addressed byte, then consecutive bytes, wrapping from the top address to zero.
- R5: A page write (0x02) or status write (0x01) while the latch is clear is ignored: memory and status are unchanged and `busy` stays 0.
- R6: Page-write data fills the page of the start address. Only the low log2(`PAGE_BYTES`) index bits advance, so the upper address bits stay fixed and extra bytes wrap and overwrite earlier ones.
- R7: A commit happens only on a chip-select rise flagged as byte-aligned, after at least one data byte; any other rise discards the staged data and leaves the latch as it was.
- R8: Page bytes not received in the frame keep their old contents.
- R9: A commit makes `busy` high. The write cycle ends with a single-cycle `wc_done` pulse, after which `busy` is low and the write-enable latch is clear.
- R10: While `busy` is high, every instruction except status read is ignored, and status read returns 0xFF.
- R11: Each commit raises `prot_req` for one cycle with the page base (or the status flag). A refused grant leaves memory and status unchanged, gives no `wc_done`, and keeps the latch set.
- R12: A granted status write stores data bits 7, 3 and 2 at the end of its write cycle, shows them on `sr_wpen`/`sr_bp` and in the status byte, and clears the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_fall | input | 1 | Pulse: chip select went active |
| cs_rise | input | 1 | Pulse: chip select went inactive |
| cs_aligned | input | 1 | With `cs_rise`: the rise fell on a byte boundary |
| rx_valid | input | 1 | Pulse: a whole byte was received |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte to shift out in the next slot |
| tx_load | output | 1 | Pulse: `tx_byte` was refreshed |
| tx_oe | output | 1 | Serial output should be driven |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (with `mem_en`) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after a read strobe |
| prot_req | output | 1 | Policy request for a pending commit |
| prot_status | output | 1 | Request concerns the status register |
| prot_addr | output | ADDR_W | Page base address of the request |
| prot_grant | input | 1 | Same-cycle policy answer |
| sr_bp | output | 2 | Stored block-protect field |
| sr_wpen | output | 1 | Stored protect-pin enable bit |
| busy | output | 1 | Internal write cycle in progress |
| wc_done | output | 1 | Pulse: write cycle finished |

## Verification
A stuck or wrongly cleared write-enable latch shows in the next status read as bit 1. It also shows as a page write that either never raises `busy` or programs memory it should not. A page index that carries into the upper address bits, or a valid mask that is lost, corrupts bytes of neighbouring pages or of the same page. That corruption is visible only once the write cycle ends and the locations are read back, so every write is followed by reads of the target, of the wrapped slots and of an adjacent page. A program engine that leaves its end state late, repeats its done pulse or ignores a refusal shows at `wc_done`, `busy` and `mem_we` within a cycle or two of the event.

// File: rtl/ee_cmd_pkg.sv
package ee_cmd_pkg;

    typedef enum logic [3:0] {
        F_IDLE,
        F_OPC,
        F_AH,
        F_AL,
        F_RD,
        F_WD,
        F_SD,
        F_SR,
        F_SKIP
    } frame_st_t;

    typedef enum logic [2:0] {
        E_IDLE,
        E_CHECK,
        E_PROG,
        E_TIMER,
        E_DONE
    } eng_st_t;

    localparam logic [2:0] CMD_SETWE = 3'b110;
    localparam logic [2:0] CMD_CLRWE = 3'b100;
    localparam logic [2:0] CMD_STRD  = 3'b101;
    localparam logic [2:0] CMD_STWR  = 3'b001;
    localparam logic [2:0] CMD_ARD   = 3'b011;
    localparam logic [2:0] CMD_PGWR  = 3'b010;

endpackage

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int PAGE_BYTES = 128,
    localparam int IDX_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_valid
);

    logic [7:0]            slot [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled <= '0;
        end else if (clr) begin
            filled <= '0;
        end else if (we) begin
            filled[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            slot[wr_idx] <= wdata;
        end
    end

    assign rd_data  = slot[rd_idx];
    assign rd_valid = filled[rd_idx];

endmodule

// File: rtl/ee_frame_fsm.sv
module ee_frame_fsm
    import ee_cmd_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int IDX_W  = 7,
    localparam int PAGE_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              busy,
    input  logic              wc_done,
    input  logic [7:0]        status_byte,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_load,
    output logic              tx_oe,
    output logic              fetch,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              wel,
    output logic              buf_clr,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic [7:0]        buf_wdata,
    output logic              commit_wr,
    output logic              commit_sr,
    output logic [PAGE_W-1:0] commit_page,
    output logic [2:0]        sr_new
);

    frame_st_t         state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  wr_idx;
    logic              is_rd, got_data, fetch_q, cap_q;
    logic              ev, op_ok, op_take;
    logic [2:0]        cmd;

    assign ev      = rx_valid && !cs_fall && !cs_rise;
    assign cmd     = rx_byte[2:0];
    assign op_ok   = (rx_byte[7:4] == 4'b0000);
    assign op_take = ev && (state == F_OPC) && op_ok && (!busy || cmd == CMD_STRD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (cs_fall) begin
            nxt = F_OPC;
        end else if (cs_rise) begin
            nxt = F_IDLE;
        end else if (rx_valid) begin
            unique case (state)
                F_OPC: begin
                    if (!op_take) begin
                        nxt = F_SKIP;
                    end else begin
                        unique case (cmd)
                            CMD_STRD: nxt = F_SR;
                            CMD_STWR: nxt = wel ? F_SD : F_SKIP;
                            CMD_ARD:  nxt = F_AH;
                            CMD_PGWR: nxt = wel ? F_AH : F_SKIP;
                            default:  nxt = F_SKIP;
                        endcase
                    end
                end
                F_AH:   nxt = F_AL;
                F_AL:   nxt = is_rd ? F_RD : F_WD;
                F_IDLE, F_RD, F_WD, F_SD, F_SR, F_SKIP: nxt = state;
                default: nxt = F_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_byte  <= '0;
            tx_load  <= 1'b0;
            wel      <= 1'b0;
            addr_q   <= '0;
            wr_idx   <= '0;
            is_rd    <= 1'b0;
            got_data <= 1'b0;
            fetch_q  <= 1'b0;
            cap_q    <= 1'b0;
            sr_new   <= '0;
        end else begin
            tx_load <= 1'b0;
            fetch_q <= 1'b0;
            cap_q   <= fetch_q;
            if (fetch_q) addr_q <= addr_q + ADDR_W'(1);
            if (cap_q) begin
                tx_byte <= mem_rdata;
                tx_load <= 1'b1;
            end
            if (wc_done) begin
                wel <= 1'b0;
            end else if (op_take && cmd == CMD_SETWE) begin
                wel <= 1'b1;
            end else if (op_take && cmd == CMD_CLRWE) begin
                wel <= 1'b0;
            end
            if (cs_fall) got_data <= 1'b0;
            if (ev) begin
                unique case (state)
                    F_OPC: begin
                        is_rd    <= (cmd == CMD_ARD);
                        got_data <= 1'b0;
                        if (op_take && cmd == CMD_STRD) begin
                            tx_byte <= status_byte;
                            tx_load <= 1'b1;
                        end
                    end
                    F_AH: addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
                    F_AL: begin
                        addr_q  <= {addr_q[ADDR_W-9:0], rx_byte};
                        wr_idx  <= rx_byte[IDX_W-1:0];
                        fetch_q <= is_rd;
                    end
                    F_RD: fetch_q <= 1'b1;
                    F_WD: begin
                        wr_idx   <= wr_idx + IDX_W'(1);
                        got_data <= 1'b1;
                    end
                    F_SD: begin
                        if (!got_data) sr_new <= {rx_byte[7], rx_byte[3:2]};
                        got_data <= 1'b1;
                    end
                    F_SR: begin
                        tx_byte <= status_byte;
                        tx_load <= 1'b1;
                    end
                    F_IDLE, F_SKIP: ;
                    default: ;
                endcase
            end
        end
    end

    assign tx_oe       = (state == F_RD) || (state == F_SR);
    assign fetch       = fetch_q;
    assign fetch_addr  = addr_q;
    assign buf_clr     = ev && (state == F_AL) && !is_rd;
    assign buf_we      = ev && (state == F_WD);
    assign buf_idx     = wr_idx;
    assign buf_wdata   = rx_byte;
    assign commit_wr   = cs_rise && cs_aligned && (state == F_WD) && got_data;
    assign commit_sr   = cs_rise && cs_aligned && (state == F_SD) && got_data;
    assign commit_page = addr_q[ADDR_W-1:IDX_W];

    assert_page_frame_has_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_WD || state == F_SD) |-> wel);

    assert_no_stream_after_bad_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_SKIP && !cs_fall) |=> !tx_load || $past(cap_q));

endmodule

// File: rtl/ee_prog_engine.sv
module ee_prog_engine
    import ee_cmd_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int IDX_W     = 7,
    parameter int WC_CYCLES = 400,
    localparam int PAGE_W = ADDR_W - IDX_W,
    localparam int CNT_W  = $clog2(WC_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_wr,
    input  logic              commit_sr,
    input  logic [PAGE_W-1:0] commit_page,
    input  logic [2:0]        sr_new,
    input  logic              prot_grant,
    input  logic [7:0]        buf_data,
    input  logic              buf_valid,
    output logic [IDX_W-1:0]  buf_rd_idx,
    output logic              busy,
    output logic              wc_done,
    output logic              prot_req,
    output logic              prot_status,
    output logic [ADDR_W-1:0] prot_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [1:0]        sr_bp,
    output logic              sr_wpen
);

    eng_st_t           state, nxt;
    logic [PAGE_W-1:0] page;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  cnt;
    logic              is_sr;
    logic [2:0]        sr_stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= E_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            E_IDLE:  if (commit_wr || commit_sr) nxt = E_CHECK;
            E_CHECK: nxt = !prot_grant ? E_IDLE : (is_sr ? E_TIMER : E_PROG);
            E_PROG:  if (idx == IDX_W'((1 << IDX_W) - 1)) nxt = E_TIMER;
            E_TIMER: if (cnt == CNT_W'(WC_CYCLES - 1)) nxt = E_DONE;
            E_DONE:  nxt = E_IDLE;
            default: nxt = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page     <= '0;
            idx      <= '0;
            cnt      <= '0;
            is_sr    <= 1'b0;
            sr_stage <= '0;
            sr_bp    <= '0;
            sr_wpen  <= 1'b0;
        end else begin
            unique case (state)
                E_IDLE: begin
                    if (commit_wr || commit_sr) begin
                        page     <= commit_page;
                        is_sr    <= commit_sr;
                        sr_stage <= sr_new;
                    end
                    idx <= '0;
                    cnt <= '0;
                end
                E_CHECK: ;
                E_PROG:  idx <= idx + IDX_W'(1);
                E_TIMER: cnt <= cnt + CNT_W'(1);
                E_DONE: begin
                    if (is_sr) begin
                        sr_wpen <= sr_stage[2];
                        sr_bp   <= sr_stage[1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy        = (state != E_IDLE);
    assign wc_done     = (state == E_DONE);
    assign prot_req    = (state == E_CHECK);
    assign prot_status = is_sr;
    assign prot_addr   = {page, {IDX_W{1'b0}}};
    assign buf_rd_idx  = idx;
    assign mem_we      = (state == E_PROG) && buf_valid;
    assign mem_addr    = {page, idx};
    assign mem_wdata   = buf_data;

    assert_done_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wc_done |=> !wc_done);

    assert_done_releases_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wc_done |=> !busy);

    assert_refusal_blocks_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_req && !prot_grant) |=> (!mem_we && !wc_done));

endmodule

// File: rtl/ee_page_cmd_ctrl.sv
module ee_page_cmd_ctrl #(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 128,
    parameter int WC_CYCLES  = 400,
    localparam int IDX_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        tx_byte,
    output logic              tx_load,
    output logic              tx_oe,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              prot_req,
    output logic              prot_status,
    output logic [ADDR_W-1:0] prot_addr,
    input  logic              prot_grant,
    output logic [1:0]        sr_bp,
    output logic              sr_wpen,
    output logic              busy,
    output logic              wc_done
);

    logic              fr_fetch, wel, buf_clr, buf_we, commit_wr, commit_sr;
    logic              eng_we, buf_valid;
    logic [ADDR_W-1:0] fr_addr, eng_addr;
    logic [IDX_W-1:0]  buf_wr_idx, buf_rd_idx;
    logic [7:0]        buf_wdata, buf_data, status_byte;
    logic [PAGE_W-1:0] commit_page;
    logic [2:0]        sr_new;

    assign status_byte = busy ? 8'hFF : {sr_wpen, 3'b000, sr_bp, wel, 1'b0};

    ee_frame_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .busy(busy), .wc_done(wc_done), .status_byte(status_byte),
        .mem_rdata(mem_rdata),
        .tx_byte(tx_byte), .tx_load(tx_load), .tx_oe(tx_oe),
        .fetch(fr_fetch), .fetch_addr(fr_addr), .wel(wel),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_wr_idx), .buf_wdata(buf_wdata),
        .commit_wr(commit_wr), .commit_sr(commit_sr), .commit_page(commit_page),
        .sr_new(sr_new)
    );

    ee_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clr(buf_clr), .we(buf_we), .wr_idx(buf_wr_idx), .wdata(buf_wdata),
        .rd_idx(buf_rd_idx), .rd_data(buf_data), .rd_valid(buf_valid)
    );

    ee_prog_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WC_CYCLES(WC_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .commit_wr(commit_wr), .commit_sr(commit_sr), .commit_page(commit_page),
        .sr_new(sr_new), .prot_grant(prot_grant),
        .buf_data(buf_data), .buf_valid(buf_valid), .buf_rd_idx(buf_rd_idx),
        .busy(busy), .wc_done(wc_done),
        .prot_req(prot_req), .prot_status(prot_status), .prot_addr(prot_addr),
        .mem_we(eng_we), .mem_addr(eng_addr), .mem_wdata(mem_wdata),
        .sr_bp(sr_bp), .sr_wpen(sr_wpen)
    );

    assign mem_en   = eng_we | fr_fetch;
    assign mem_we   = eng_we;
    assign mem_addr = busy ? eng_addr : fr_addr;

    assert_no_array_read_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fr_fetch);

    assert_write_only_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

endmodule

// File: tb/test_ee_page_cmd_ctrl.sv
module test_ee_page_cmd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 10;
    localparam int MEMN = 1 << AW;
    localparam int WC   = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_fall = 1'b0, cs_rise = 1'b0, cs_aligned = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic [7:0]    tx_byte;
    logic          tx_load, tx_oe, mem_en, mem_we;
    logic [AW-1:0] mem_addr, prot_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          prot_req, prot_status, prot_grant;
    logic [1:0]    sr_bp;
    logic          sr_wpen, busy, wc_done;
    logic          deny = 1'b0;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    int prot_cnt = 0;
    logic [AW-1:0] last_prot = '0;
    logic          finished = 1'b0;

    logic [7:0] mem [MEMN];
    logic [7:0] expm [MEMN];

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign prot_grant = !deny;

    ee_page_cmd_ctrl #(.ADDR_W(AW), .PAGE_BYTES(128), .WC_CYCLES(WC)) i_ee_page_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte), .tx_load(tx_load), .tx_oe(tx_oe),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .prot_req(prot_req), .prot_status(prot_status),
        .prot_addr(prot_addr), .prot_grant(prot_grant), .sr_bp(sr_bp), .sr_wpen(sr_wpen),
        .busy(busy), .wc_done(wc_done)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    always @(negedge clk) begin
        if (wc_done) done_cnt++;
        if (prot_req) begin
            prot_cnt++;
            last_prot = prot_addr;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        tick(4);
    endtask

    task automatic fbegin();
        cs_fall = 1'b1;
        @(negedge clk);
        cs_fall = 1'b0;
        tick(1);
    endtask

    task automatic fend(input logic aligned);
        cs_rise = 1'b1; cs_aligned = aligned;
        @(negedge clk);
        cs_rise = 1'b0; cs_aligned = 1'b0;
        tick(2);
    endtask

    task automatic one_byte_cmd(input logic [7:0] op);
        fbegin(); send(op); fend(1'b1);
    endtask

    task automatic status_rd(output logic [7:0] s);
        fbegin(); send(8'h05); s = tx_byte; fend(1'b1);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    endtask

    task automatic read_chk(input string tag, input logic [15:0] a, input int n);
        fbegin(); send(8'h03); send(a[15:8]); send(a[7:0]);
        for (int i = 0; i < n; i++) begin
            chk(tag, {8'h00, tx_byte}, {8'h00, expm[(int'(a) + i) % MEMN]});
            send(8'h00);
        end
        fend(1'b1);
    endtask

    task automatic test_reset();
        logic [7:0] s;
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 tx_oe", {15'd0, tx_oe}, 16'd0);
        chk("R1 wc_done", {15'd0, wc_done}, 16'd0);
        status_rd(s);
        chk("R1 status after reset", {8'h00, s}, 16'h0000);
    endtask

    task automatic test_decode();
        logic [7:0] s;
        one_byte_cmd(8'h0E);
        status_rd(s);
        chk("R2 set latch with bit3 set", {8'h00, s}, 16'h0002);
        one_byte_cmd(8'h0C);
        status_rd(s);
        chk("R2 clear latch with bit3 set", {8'h00, s}, 16'h0000);
        one_byte_cmd(8'h16);
        status_rd(s);
        chk("R2 upper nibble nonzero rejected", {8'h00, s}, 16'h0000);
    endtask

    task automatic test_invalid();
        logic [7:0] s;
        fbegin(); send(8'h07);
        send(8'h05);
        chk("R3 no output after bad op", {15'd0, tx_oe}, 16'd0);
        send(8'h06);
        fend(1'b1);
        status_rd(s);
        chk("R3 later set-latch in bad frame ignored", {8'h00, s}, 16'h0000);
    endtask

    task automatic test_read();
        read_chk("R4 read high bits ignored", 16'hFC05, 3);
        read_chk("R4 read wraps to zero", 16'(MEMN - 2), 4);
    endtask

    task automatic test_no_wel();
        int d0;
        d0 = done_cnt;
        fbegin(); send(8'h02); send(8'h01); send(8'h00); send(8'h99); fend(1'b1);
        chk("R5 write without latch no busy", {15'd0, busy}, 16'd0);
        tick(WC + 200);
        chk("R5 write without latch no cycle", 16'(done_cnt - d0), 16'd0);
        read_chk("R5 memory unchanged", 16'h0100, 1);
    endtask

    task automatic test_page_write();
        logic [7:0] s;
        int d0;
        d0 = done_cnt;
        one_byte_cmd(8'h06);
        fbegin(); send(8'h02); send(8'h00); send(8'h7E);
        for (int i = 0; i < 4; i++) begin
            send(8'hA0 + 8'(i));
            expm[(126 + i) % 128] = 8'hA0 + 8'(i);
        end
        fend(1'b1);
        chk("R9 busy after commit", {15'd0, busy}, 16'd1);
        status_rd(s);
        chk("R10 status while busy", {8'h00, s}, 16'h00FF);
        fbegin(); send(8'h03); send(8'h00); send(8'h00); send(8'h00);
        chk("R10 read refused while busy", {15'd0, tx_oe}, 16'd0);
        fend(1'b1);
        wait_idle();
        chk("R9 one done pulse", 16'(done_cnt - d0), 16'd1);
        status_rd(s);
        chk("R9 latch cleared at end", {8'h00, s}, 16'h0000);
        read_chk("R6 wrap within page tail", 16'h007E, 2);
        read_chk("R6 wrap within page head", 16'h0000, 2);
        read_chk("R8 unreceived byte kept", 16'h0002, 1);
        read_chk("R6 next page untouched", 16'h0080, 1);
    endtask

    task automatic test_overrun();
        one_byte_cmd(8'h06);
        fbegin(); send(8'h02); send(8'h01); send(8'h00);
        for (int i = 0; i < 130; i++) begin
            send(8'h40 + 8'(i));
            expm[256 + (i % 128)] = 8'h40 + 8'(i);
        end
        fend(1'b1);
        wait_idle();
        read_chk("R6 overrun overwrites start", 16'h0100, 3);
        read_chk("R6 overrun page end", 16'h017F, 1);
    endtask

    task automatic test_unaligned();
        logic [7:0] s;
        int d0;
        d0 = done_cnt;
        one_byte_cmd(8'h06);
        fbegin(); send(8'h02); send(8'h02); send(8'h00); send(8'h55); fend(1'b0);
        chk("R7 unaligned rise no busy", {15'd0, busy}, 16'd0);
        fbegin(); send(8'h02); send(8'h02); send(8'h00); fend(1'b1);
        chk("R7 no data no busy", {15'd0, busy}, 16'd0);
        tick(WC + 200);
        chk("R7 no cycle started", 16'(done_cnt - d0), 16'd0);
        read_chk("R7 memory unchanged", 16'h0200, 1);
        status_rd(s);
        chk("R7 latch kept", {8'h00, s}, 16'h0002);
        one_byte_cmd(8'h04);
    endtask

    task automatic test_protect();
        logic [7:0] s;
        int d0, p0;
        d0 = done_cnt; p0 = prot_cnt;
        deny = 1'b1;
        one_byte_cmd(8'h06);
        fbegin(); send(8'h02); send(8'h01); send(8'h85); send(8'h11); send(8'h22); fend(1'b1);
        wait_idle();
        chk("R11 one request", 16'(prot_cnt - p0), 16'd1);
        chk("R11 page base", {6'd0, last_prot}, 16'h0180);
        chk("R11 refused no done", 16'(done_cnt - d0), 16'd0);
        read_chk("R11 refused memory unchanged", 16'h0185, 2);
        status_rd(s);
        chk("R11 latch kept after refusal", {8'h00, s}, 16'h0002);
        deny = 1'b0;
        one_byte_cmd(8'h04);
    endtask

    task automatic test_status_write();
        logic [7:0] s;
        fbegin(); send(8'h01); send(8'hFF); fend(1'b1);
        chk("R5 status write without latch no busy", {15'd0, busy}, 16'd0);
        status_rd(s);
        chk("R5 status unchanged", {8'h00, s}, 16'h0000);
        one_byte_cmd(8'h06);
        fbegin(); send(8'h01); send(8'hFF); fend(1'b1);
        chk("R12 status write busy", {15'd0, busy}, 16'd1);
        wait_idle();
        chk("R12 stored protect field", {14'd0, sr_bp}, 16'd3);
        chk("R12 stored pin enable", {15'd0, sr_wpen}, 16'd1);
        status_rd(s);
        chk("R12 status readback", {8'h00, s}, 16'h008C);
    endtask

    initial begin
        for (int i = 0; i < MEMN; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            expm[i] = 8'(i * 7 + 3);
        end
        tick(3);
        rst_n = 1'b1;
        tick(2);
        test_reset();
        test_decode();
        test_invalid();
        test_read();
        test_no_wel();
        test_page_write();
        test_overrun();
        test_unaligned();
        test_protect();
        test_status_write();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule